// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block carries out the processor-side bookkeeping when a maskable interrupt is taken, and the reverse operation when the handler finishes. When an accept strobe arrives and the interrupt is allowed, the block captures the restart PC, the current PSW, the cause code and the handler address. It then walks through a fixed series of one-clock steps. First it saves the PC into a shadow register, then it saves the PSW into a second shadow register. Next it puts the cause code into the low half of the cause register. After that it issues a PSW write with interrupts disabled and the exception-pending flag cleared, and finally it issues a PC write to the handler address.

A return strobe reloads PC and PSW from the shadow registers in the same cycle. Software can overwrite the shadow PC, the shadow PSW and the whole cause register through a small write port. This lets a handler restore copies it saved before re-enabling nested interrupts. While the sequence runs, a busy output is high, and the acknowledge-permitted output stays low whenever the incoming PSW has its disable or non-maskable-in-progress bit set.

Top module: `intr_entry_seq`

## Requirements
- R1: After reset the shadow PC, shadow PSW and cause register read zero, busy is low and neither PC write nor PSW write is asserted.
- R2: An accept taken in an idle cycle raises busy from the next cycle for exactly five cycles. Steps run in this order: shadow PC written at the end of step 1, shadow PSW at the end of step 2, cause register at the end of step 3, PSW write during step 4, PC write during step 5.
- R3: The shadow PC receives the restart PC captured with the accept.
- R4: The shadow PSW receives the PSW value captured with the accept.
- R5: The cause register's low 16 bits receive the captured code, and its upper 16 bits keep their previous value.
- R6: The PSW issued in step 4 equals the captured PSW with bit 5 (interrupt disable) set and bit 6 (exception pending) cleared, all other bits unchanged.
- R7: The PC issued in step 5 equals the captured handler address, and busy falls in the next cycle.
- R8: Acknowledge-permitted is high only when idle with PSW bit 5 and bit 7 (non-maskable in progress) both clear. An accept while it is low is ignored.
- R9: A return strobe in an idle cycle with no accept taken asserts PC write and PSW write in that same cycle, driving the shadow PC and shadow PSW values.
- R10: An idle software write updates the register picked by the select code: 0 = shadow PC, 1 = shadow PSW, 2 = whole cause register, 3 = nothing. It is ignored in a cycle where an accept is taken.
- R11: While busy, return strobes and software writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| accept_i | input | 1 | Maskable interrupt accept strobe |
| return_i | input | 1 | Handler return strobe |
| restart_pc_i | input | XLEN | PC to resume at |
| cur_psw_i | input | PSW_W | Current PSW |
| exc_code_i | input | CODE_W | Cause code of the interrupt |
| handler_pc_i | input | XLEN | Handler entry address |
| sw_wr_i | input | 1 | Software write strobe |
| sw_sel_i | input | 2 | Software write target select |
| sw_data_i | input | XLEN | Software write data |
| ack_ok_o | output | 1 | An accept would be taken this cycle |
| busy_o | output | 1 | Entry sequence in progress |
| eipc_o | output | XLEN | Shadow PC |
| eipsw_o | output | PSW_W | Shadow PSW |
| ecr_o | output | ECR_W | Cause register |
| psw_we_o | output | 1 | PSW write strobe |
| psw_o | output | PSW_W | PSW write value |
| pc_we_o | output | 1 | PC write strobe |
| pc_o | output | XLEN | PC write value |

## Verification
The hardest situation to reach is contention between the entry sequence and the other two writers of the shadow state. One case is a software write or return that lands mid-sequence. Another is an accept that coincides with a software write or return in the same idle cycle. The stimulus holds return and write strobes high across whole entry sequences and fires them together with an accept. It also retries accepts while the PSW has the disable or non-maskable bit set. A behavioural model checks every output on every clock. Shadow and cause contents are read straight from the ports after each disputed cycle.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_SAVE_PC  = 3'd1,
      ST_SAVE_PSW = 3'd2,
      ST_CAUSE    = 3'd3,
      ST_MODE     = 3'd4,
      ST_JUMP     = 3'd5
   } step_e;

   localparam logic [1:0] SEL_SHPC  = 2'd0;
   localparam logic [1:0] SEL_SHPSW = 2'd1;
   localparam logic [1:0] SEL_CAUSE = 2'd2;
endpackage

// File: rtl/intr_step_fsm.sv
module intr_step_fsm
   import intr_seq_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  start_i,
   output step_e step_o,
   output logic  busy_o
);
   step_e step_q, step_d;

   always_comb begin
      step_d = step_q;
      unique case (step_q)
         ST_IDLE:     if (start_i) step_d = ST_SAVE_PC;
         ST_SAVE_PC:  step_d = ST_SAVE_PSW;
         ST_SAVE_PSW: step_d = ST_CAUSE;
         ST_CAUSE:    step_d = ST_MODE;
         ST_MODE:     step_d = ST_JUMP;
         ST_JUMP:     step_d = ST_IDLE;
         default:     step_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step_q <= ST_IDLE;
      else        step_q <= step_d;
   end

   assign step_o = step_q;
   assign busy_o = (step_q != ST_IDLE);
endmodule

// File: rtl/intr_shadow_regs.sv
module intr_shadow_regs #(
   parameter int XLEN   = 32,
   parameter int PSW_W  = 32,
   parameter int ECR_W  = 32,
   parameter int CODE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pc_we_i,
   input  logic [XLEN-1:0]   pc_d_i,
   input  logic              psw_we_i,
   input  logic [PSW_W-1:0]  psw_d_i,
   input  logic              code_we_i,
   input  logic [CODE_W-1:0] code_d_i,
   input  logic              ecr_we_i,
   input  logic [ECR_W-1:0]  ecr_d_i,
   output logic [XLEN-1:0]   pc_q_o,
   output logic [PSW_W-1:0]  psw_q_o,
   output logic [ECR_W-1:0]  ecr_q_o
);
   logic [XLEN-1:0]  pc_q;
   logic [PSW_W-1:0] psw_q;
   logic [ECR_W-1:0] ecr_q;
   logic [ECR_W-1:0] ecr_code_merge;

   generate
      if (ECR_W > CODE_W) begin : g_keep_upper
         assign ecr_code_merge = {ecr_q[ECR_W-1:CODE_W], code_d_i};
      end else begin : g_full_code
         assign ecr_code_merge = code_d_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= '0;
         psw_q <= '0;
         ecr_q <= '0;
      end else begin
         if (pc_we_i)        pc_q  <= pc_d_i;
         if (psw_we_i)       psw_q <= psw_d_i;
         if (code_we_i)      ecr_q <= ecr_code_merge;
         else if (ecr_we_i)  ecr_q <= ecr_d_i;
      end
   end

   assign pc_q_o  = pc_q;
   assign psw_q_o = psw_q;
   assign ecr_q_o = ecr_q;
endmodule

// File: rtl/intr_psw_mod.sv
module intr_psw_mod #(
   parameter int PSW_W  = 32,
   parameter int ID_BIT = 5,
   parameter int EP_BIT = 6
) (
   input  logic [PSW_W-1:0] psw_i,
   output logic [PSW_W-1:0] psw_o
);
   localparam logic [PSW_W-1:0] SET_MASK = PSW_W'(1) << ID_BIT;
   localparam logic [PSW_W-1:0] CLR_MASK = ~(PSW_W'(1) << EP_BIT);

   assign psw_o = (psw_i | SET_MASK) & CLR_MASK;
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
   import intr_seq_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int PSW_W  = 32,
   parameter int ECR_W  = 32,
   parameter int CODE_W = 16,
   parameter int ID_BIT = 5,
   parameter int EP_BIT = 6,
   parameter int NP_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_i,
   input  logic              return_i,
   input  logic [XLEN-1:0]   restart_pc_i,
   input  logic [PSW_W-1:0]  cur_psw_i,
   input  logic [CODE_W-1:0] exc_code_i,
   input  logic [XLEN-1:0]   handler_pc_i,
   input  logic              sw_wr_i,
   input  logic [1:0]        sw_sel_i,
   input  logic [XLEN-1:0]   sw_data_i,
   output logic              ack_ok_o,
   output logic              busy_o,
   output logic [XLEN-1:0]   eipc_o,
   output logic [PSW_W-1:0]  eipsw_o,
   output logic [ECR_W-1:0]  ecr_o,
   output logic              psw_we_o,
   output logic [PSW_W-1:0]  psw_o,
   output logic              pc_we_o,
   output logic [XLEN-1:0]   pc_o
);
   generate
      if (PSW_W > XLEN || ECR_W > XLEN) begin : g_bad_width
         $error("PSW_W and ECR_W must not exceed XLEN");
      end
      if (CODE_W > ECR_W) begin : g_bad_code
         $error("CODE_W must not exceed ECR_W");
      end
      if (ID_BIT >= PSW_W || EP_BIT >= PSW_W || NP_BIT >= PSW_W) begin : g_bad_bit
         $error("PSW flag positions must lie inside PSW_W");
      end
      if (ID_BIT == EP_BIT) begin : g_bad_alias
         $error("ID and EP flags must be distinct bits");
      end
   endgenerate

   step_e step;
   logic  busy;
   logic  accept_take, ret_take, sw_take;

   logic [XLEN-1:0]   cap_pc, cap_hnd;
   logic [PSW_W-1:0]  cap_psw, mod_psw;
   logic [CODE_W-1:0] cap_code;

   logic [XLEN-1:0]  sh_pc;
   logic [PSW_W-1:0] sh_psw;
   logic [ECR_W-1:0] sh_ecr;

   assign ack_ok_o    = !busy && !cur_psw_i[ID_BIT] && !cur_psw_i[NP_BIT];
   assign accept_take = accept_i && ack_ok_o;
   assign ret_take    = return_i && !busy && !accept_take;
   assign sw_take     = sw_wr_i && !busy && !accept_take;

   intr_step_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (accept_take),
      .step_o  (step),
      .busy_o  (busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_pc   <= '0;
         cap_hnd  <= '0;
         cap_psw  <= '0;
         cap_code <= '0;
      end else if (accept_take) begin
         cap_pc   <= restart_pc_i;
         cap_hnd  <= handler_pc_i;
         cap_psw  <= cur_psw_i;
         cap_code <= exc_code_i;
      end
   end

   intr_shadow_regs #(
      .XLEN   (XLEN),
      .PSW_W  (PSW_W),
      .ECR_W  (ECR_W),
      .CODE_W (CODE_W)
   ) u_shadow (
      .clk       (clk),
      .rst_n     (rst_n),
      .pc_we_i   ((step == ST_SAVE_PC) || (sw_take && sw_sel_i == SEL_SHPC)),
      .pc_d_i    (busy ? cap_pc : sw_data_i),
      .psw_we_i  ((step == ST_SAVE_PSW) || (sw_take && sw_sel_i == SEL_SHPSW)),
      .psw_d_i   (busy ? cap_psw : sw_data_i[PSW_W-1:0]),
      .code_we_i (step == ST_CAUSE),
      .code_d_i  (cap_code),
      .ecr_we_i  (sw_take && sw_sel_i == SEL_CAUSE),
      .ecr_d_i   (sw_data_i[ECR_W-1:0]),
      .pc_q_o    (sh_pc),
      .psw_q_o   (sh_psw),
      .ecr_q_o   (sh_ecr)
   );

   intr_psw_mod #(
      .PSW_W  (PSW_W),
      .ID_BIT (ID_BIT),
      .EP_BIT (EP_BIT)
   ) u_pswmod (
      .psw_i (cap_psw),
      .psw_o (mod_psw)
   );

   assign busy_o   = busy;
   assign eipc_o   = sh_pc;
   assign eipsw_o  = sh_psw;
   assign ecr_o    = sh_ecr;
   assign psw_we_o = ret_take || (step == ST_MODE);
   assign psw_o    = busy ? mod_psw : sh_psw;
   assign pc_we_o  = ret_take || (step == ST_JUMP);
   assign pc_o     = busy ? cap_hnd : sh_pc;
endmodule

// File: rtl/intr_entry_seq_chk.sv
module intr_entry_seq_chk #(
   parameter int XLEN   = 32,
   parameter int PSW_W  = 32,
   parameter int ID_BIT = 5,
   parameter int EP_BIT = 6,
   parameter int NP_BIT = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             accept_i,
   input logic             return_i,
   input logic [PSW_W-1:0] cur_psw_i,
   input logic             sw_wr_i,
   input logic             ack_ok_o,
   input logic             busy_o,
   input logic [XLEN-1:0]  eipc_o,
   input logic [PSW_W-1:0] eipsw_o,
   input logic             psw_we_o,
   input logic [PSW_W-1:0] psw_o,
   input logic             pc_we_o,
   input logic [XLEN-1:0]  pc_o
);
   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_i && ack_ok_o) |=> busy_o);

   p_ack_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o || cur_psw_i[ID_BIT] || cur_psw_i[NP_BIT]) |-> !ack_ok_o);

   p_jump_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $past(pc_we_o));

   p_mode_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && psw_we_o) |-> (psw_o[ID_BIT] && !psw_o[EP_BIT]));

   p_shpc_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !sw_wr_i) |=> $stable(eipc_o));

   p_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (return_i && !busy_o && !(accept_i && ack_ok_o))
      |-> (pc_we_o && psw_we_o && pc_o == eipc_o && psw_o == eipsw_o));
endmodule

bind intr_entry_seq intr_entry_seq_chk #(
   .XLEN   (XLEN),
   .PSW_W  (PSW_W),
   .ID_BIT (ID_BIT),
   .EP_BIT (EP_BIT),
   .NP_BIT (NP_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .accept_i  (accept_i),
   .return_i  (return_i),
   .cur_psw_i (cur_psw_i),
   .sw_wr_i   (sw_wr_i),
   .ack_ok_o  (ack_ok_o),
   .busy_o    (busy_o),
   .eipc_o    (eipc_o),
   .eipsw_o   (eipsw_o),
   .psw_we_o  (psw_we_o),
   .psw_o     (psw_o),
   .pc_we_o   (pc_we_o),
   .pc_o      (pc_o)
);

// File: tb/sim_intr_entry_seq.sv
module sim_intr_entry_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        accept_i = 1'b0, return_i = 1'b0, sw_wr_i = 1'b0;
   logic [31:0] restart_pc_i = '0, cur_psw_i = '0, handler_pc_i = '0, sw_data_i = '0;
   logic [15:0] exc_code_i = '0;
   logic [1:0]  sw_sel_i = '0;
   logic        ack_ok_o, busy_o, psw_we_o, pc_we_o;
   logic [31:0] eipc_o, eipsw_o, ecr_o, psw_o, pc_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // behavioural reference state
   int          m_step = 0;
   logic [31:0] m_eipc = '0, m_eipsw = '0, m_ecr = '0;
   logic [31:0] l_pc, l_psw, l_hnd;
   logic [15:0] l_code;

   always #10 clk = ~clk;

   intr_entry_seq u0 (
      .clk(clk), .rst_n(rst_n), .accept_i(accept_i), .return_i(return_i),
      .restart_pc_i(restart_pc_i), .cur_psw_i(cur_psw_i), .exc_code_i(exc_code_i),
      .handler_pc_i(handler_pc_i), .sw_wr_i(sw_wr_i), .sw_sel_i(sw_sel_i),
      .sw_data_i(sw_data_i), .ack_ok_o(ack_ok_o), .busy_o(busy_o),
      .eipc_o(eipc_o), .eipsw_o(eipsw_o), .ecr_o(ecr_o), .psw_we_o(psw_we_o),
      .psw_o(psw_o), .pc_we_o(pc_we_o), .pc_o(pc_o)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare all outputs against the model, then advance one clock
   task automatic cyc();
      bit exp_busy, exp_ack, acc, ret, exp_pwe, exp_cwe;
      logic [31:0] exp_psw, exp_pc;
      #1;
      exp_busy = (m_step != 0);
      exp_ack  = !exp_busy && !cur_psw_i[5] && !cur_psw_i[7];
      acc      = accept_i && exp_ack;
      ret      = return_i && !exp_busy && !acc;
      exp_pwe  = ret || (m_step == 4);
      exp_cwe  = ret || (m_step == 5);
      exp_psw  = (m_step == 4) ? ((l_psw | 32'h20) & ~32'h40) : m_eipsw;
      exp_pc   = (m_step == 5) ? l_hnd : m_eipc;
      chk(busy_o == exp_busy, "R2 busy", 32'(busy_o), 32'(exp_busy));
      chk(ack_ok_o == exp_ack, "R8 ack_ok", 32'(ack_ok_o), 32'(exp_ack));
      chk(eipc_o == m_eipc, exp_busy ? "R3/R11 shadow PC" : "R3/R10 shadow PC", eipc_o, m_eipc);
      chk(eipsw_o == m_eipsw, exp_busy ? "R4/R11 shadow PSW" : "R4/R10 shadow PSW", eipsw_o, m_eipsw);
      chk(ecr_o == m_ecr, "R5/R10 cause", ecr_o, m_ecr);
      chk(psw_we_o == exp_pwe, ret ? "R9 psw_we" : "R2/R11 psw_we", 32'(psw_we_o), 32'(exp_pwe));
      chk(pc_we_o == exp_cwe, ret ? "R9 pc_we" : "R2/R11 pc_we", 32'(pc_we_o), 32'(exp_cwe));
      if (exp_pwe) chk(psw_o == exp_psw, ret ? "R9 psw value" : "R6 psw value", psw_o, exp_psw);
      if (exp_cwe) chk(pc_o == exp_pc, ret ? "R9 pc value" : "R7 pc value", pc_o, exp_pc);
      @(posedge clk);
      case (m_step)
         0: if (acc) begin
               l_pc = restart_pc_i; l_psw = cur_psw_i; l_hnd = handler_pc_i; l_code = exc_code_i;
               m_step = 1;
            end else if (sw_wr_i) begin
               if (sw_sel_i == 2'd0) m_eipc  = sw_data_i;
               if (sw_sel_i == 2'd1) m_eipsw = sw_data_i;
               if (sw_sel_i == 2'd2) m_ecr   = sw_data_i;
            end
         1: begin m_eipc = l_pc; m_step = 2; end
         2: begin m_eipsw = l_psw; m_step = 3; end
         3: begin m_ecr = {m_ecr[31:16], l_code}; m_step = 4; end
         4: m_step = 5;
         default: m_step = 0;
      endcase
      @(negedge clk);
   endtask

   task automatic idle_in();
      accept_i = 0; return_i = 0; sw_wr_i = 0;
   endtask

   task automatic enter(input logic [31:0] pc, input logic [31:0] psw,
                        input logic [15:0] code, input logic [31:0] hnd);
      restart_pc_i = pc; cur_psw_i = psw; exc_code_i = code; handler_pc_i = hnd;
      accept_i = 1;
      cyc();
      accept_i = 0;
      for (int i = 0; i < 6; i++) cyc();
   endtask

   task automatic sw_write(input logic [1:0] sel, input logic [31:0] d);
      sw_wr_i = 1; sw_sel_i = sel; sw_data_i = d;
      cyc();
      sw_wr_i = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(eipc_o == 0 && eipsw_o == 0 && ecr_o == 0, "R1 shadows zero", eipc_o | eipsw_o | ecr_o, 0);
      chk(!busy_o && !pc_we_o && !psw_we_o, "R1 idle strobes", {busy_o, pc_we_o, psw_we_o}, 0);
      rst_n = 1;
      @(negedge clk);
      cyc();

      // R10: preset upper half of cause, then entry keeps it (R5)
      sw_write(2'd2, 32'hABCD_0000);
      cyc();
      enter(32'h0000_1000, 32'h0000_0041, 16'h0050, 32'h0000_2000);
      // R9 return
      return_i = 1; cyc(); return_i = 0; cyc();

      // R8: blocked by ID, then NP
      restart_pc_i = 32'h5555_0000; cur_psw_i = 32'h20; accept_i = 1; cyc(); cyc();
      cur_psw_i = 32'h80; cyc(); accept_i = 0; cyc();

      // R10: software writes of each target and the no-op code
      sw_write(2'd0, 32'h1234_5678);
      sw_write(2'd1, 32'h0000_00C3);
      sw_write(2'd3, 32'hDEAD_BEEF);
      return_i = 1; cyc(); return_i = 0;

      // R11: return and writes held high through a whole sequence
      cur_psw_i = 32'hFFFF_FF1F;
      restart_pc_i = 32'hCAFE_0004; exc_code_i = 16'h0123; handler_pc_i = 32'h0000_0300;
      accept_i = 1; cyc(); accept_i = 0;
      return_i = 1; sw_wr_i = 1; sw_sel_i = 2'd0; sw_data_i = 32'h0BAD_0BAD;
      for (int i = 0; i < 5; i++) cyc();
      idle_in(); cyc();

      // R10/R9: accept coincides with a write and a return
      cur_psw_i = 32'h0; return_i = 1; sw_wr_i = 1; sw_sel_i = 2'd1; sw_data_i = 32'h7777_7777;
      accept_i = 1; restart_pc_i = 32'h0000_4444; exc_code_i = 16'hFFFF; handler_pc_i = 32'h0000_8888;
      cyc(); idle_in();
      for (int i = 0; i < 6; i++) cyc();

      // varied patterns
      for (int k = 0; k < 40; k++) begin
         logic [31:0] r;
         r = $urandom;
         enter($urandom, r & 32'hFFFF_FF5F, 16'($urandom), $urandom);
         if (k % 3 == 0) sw_write(2'(k), $urandom);
         return_i = 1; cyc(); return_i = 0;
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule